// File: doc/BRIEF.md
# Codec Command Port and Power-Up Sequencer

This block sits between a host register interface and the control side of an AC97-style audio codec. Once out of reset it runs a fixed bring-up on its own. First it writes six control-word values to the codec control register, with a programmable gap of several milliseconds between writes. Then it loads a bank of 32 channel registers with a descending pattern: 0, -1, -2 and so on. When that is finished it raises a sticky done flag and opens the host port.

The host sends 24-bit command words. A set write flag gives a codec register write. A clear flag gives a read, and the 16-bit read data comes back with a valid pulse after a fixed latency. Host commands presented during the bring-up are held off with a busy flag and are accepted as soon as the block is free. The block also holds a two-bit channel enable register. Serial link framing and the analog codec are outside the block.

Top module: `codec_cmd_seq`

## Requirements
- R1: While reset is held, ctrlWe, chanWe, codecValid and hostRdValid are low, hostBusy is high, initDone is low and chanEnable is 0.
- R2: After reset, ctrlWe pulses exactly six times per bring-up, carrying 0x00a8, 0x80a8, 0x80e8, 0x80a8, 0x00a8, 0x00e8 on ctrlData in that order.
- R3: The first control write occurs in the second cycle after reset is released. Consecutive control writes are exactly GAP_MS*CLK_PER_MS clock cycles apart.
- R4: In the cycle after the sixth control write, chanWe goes high for 32 consecutive cycles. chanIdx runs 0 to 31 and chanData equals 0 minus chanIdx modulo 2^32 (0x00000000, 0xffffffff, 0xfffffffe, ...).
- R5: initDone rises in the cycle after the last channel write and stays high until the next reset. hostBusy is its complement.
- R6: In a command word, bit 23 is the write flag, bits 22:16 are the codec register address and bits 15:0 are the data. An accepted command appears on codecValid/codecWrite/codecAddr/codecData in the cycle after acceptance.
- R7: A command is accepted on a clock edge where hostCmdValid is high and hostBusy is low. A command held during busy is not dropped; it is issued after initDone rises.
- R8: For a read (bit 23 clear), hostRdValid is high exactly RD_LAT-1 cycles after the codecValid cycle of that read. hostRdData then equals the codecRdData present in the cycle before.
- R9: A hostEnWe edge while not busy loads word bit 8 into chanEnable[0] (channel 0) and bit 9 into chanEnable[1] (channel 1), visible the next cycle. While busy the write is ignored.
- R10: Commands presented on consecutive cycles after bring-up are accepted one per cycle. Each one produces its own codec cycle and, for reads, its own return pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCmdValid | input | 1 | Host command present |
| hostCmdWord | input | 24 | Command word: flag, address, data |
| hostBusy | output | 1 | Bring-up running; commands stalled |
| hostRdValid | output | 1 | Read data valid pulse |
| hostRdData | output | 16 | Returned read data |
| hostEnWe | input | 1 | Channel enable register write |
| hostEnWord | input | 2 | Enable word bits 9:8 |
| chanEnable | output | 2 | Channel enable bits, bit 0 = channel 0 |
| codecValid | output | 1 | Codec command cycle |
| codecWrite | output | 1 | Codec command is a write |
| codecAddr | output | 7 | Codec register address |
| codecData | output | 16 | Codec write data |
| codecRdData | input | 16 | Data returned by the codec |
| ctrlWe | output | 1 | Control register write strobe |
| ctrlData | output | 16 | Control register value |
| chanWe | output | 1 | Channel register write strobe |
| chanIdx | output | 5 | Channel register index |
| chanData | output | 32 | Channel register value |
| initDone | output | 1 | Bring-up complete, sticky |

## Verification
Some rules are checked on every cycle: no codec cycle follows a busy cycle, chanEnable holds steady after a busy cycle, initDone never falls, control strobes never come back to back, and each channel value is one below the one before it. Other properties can only be shown by the scenarios against the cycle-accurate model. These are the exact control values and gap lengths, the cycle where the fill starts and ends, that a held command survives the stall, the read return latency and the data captured, and that a reset in mid-bring-up restarts the whole sequence.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int CHAN_CNT = 32;
  localparam int CHAN_IW  = $clog2(CHAN_CNT);
  localparam int CHAN_DW  = 32;
  localparam int STEP_CNT = 6;
  localparam int STEP_IW  = $clog2(STEP_CNT);

  typedef struct packed {
    logic               ctrlWr;
    logic               chanWr;
    logic               hostOpen;
    logic [STEP_IW-1:0] stepIdx;
    logic [CHAN_IW-1:0] chanIdx;
  } seq_strobe_t;
endpackage

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int GAP_MS     = 5
) (
  input  logic        clk,
  input  logic        rstN,
  output seq_strobe_t strobe
);
  localparam int GAP = CLK_PER_MS * GAP_MS;
  localparam int CW  = $clog2(GAP);

  typedef enum logic [2:0] {S_START, S_CTRL, S_WAIT, S_CHAN, S_DONE} seq_state_t;

  seq_state_t         state;
  logic [STEP_IW-1:0] step;
  logic [CHAN_IW-1:0] chan;
  logic [CW-1:0]      gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_START;
      step   <= '0;
      chan   <= '0;
      gapCnt <= '0;
    end else begin
      case (state)
        S_START: state <= S_CTRL;
        S_CTRL: begin
          gapCnt <= '0;
          if (step == STEP_IW'(STEP_CNT - 1)) begin
            state <= S_CHAN;
            chan  <= '0;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (gapCnt == CW'(GAP - 2)) begin
            state <= S_CTRL;
            step  <= step + 1'b1;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        S_CHAN: begin
          if (chan == CHAN_IW'(CHAN_CNT - 1)) state <= S_DONE;
          else chan <= chan + 1'b1;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.ctrlWr   = (state == S_CTRL);
    strobe.chanWr   = (state == S_CHAN);
    strobe.hostOpen = (state == S_DONE);
    strobe.stepIdx  = step;
    strobe.chanIdx  = chan;
  end
endmodule

// File: rtl/codec_seq_dp.sv
module codec_seq_dp
  import codec_seq_pkg::*;
#(
  parameter int RD_LAT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_strobe_t        strobe,
  input  logic               hostCmdValid,
  input  logic [23:0]        hostCmdWord,
  output logic               hostRdValid,
  output logic [15:0]        hostRdData,
  input  logic               hostEnWe,
  input  logic [9:8]         hostEnWord,
  output logic [1:0]         chanEnable,
  output logic               codecValid,
  output logic               codecWrite,
  output logic [6:0]         codecAddr,
  output logic [15:0]        codecData,
  input  logic [15:0]        codecRdData,
  output logic               ctrlWe,
  output logic [15:0]        ctrlData,
  output logic               chanWe,
  output logic [CHAN_IW-1:0] chanIdx,
  output logic [CHAN_DW-1:0] chanData
);
  logic              accept;
  logic [RD_LAT-1:0] rdPipe;

  assign accept = hostCmdValid && strobe.hostOpen;

  always_comb begin
    case (strobe.stepIdx)
      STEP_IW'(0): ctrlData = 16'h00a8;
      STEP_IW'(1): ctrlData = 16'h80a8;
      STEP_IW'(2): ctrlData = 16'h80e8;
      STEP_IW'(3): ctrlData = 16'h80a8;
      STEP_IW'(4): ctrlData = 16'h00a8;
      STEP_IW'(5): ctrlData = 16'h00e8;
      default:     ctrlData = 16'h0000;
    endcase
  end

  assign ctrlWe   = strobe.ctrlWr;
  assign chanWe   = strobe.chanWr;
  assign chanIdx  = strobe.chanIdx;
  assign chanData = CHAN_DW'(0) - CHAN_DW'(strobe.chanIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codecValid <= 1'b0;
      codecWrite <= 1'b0;
      codecAddr  <= '0;
      codecData  <= '0;
      chanEnable <= '0;
      rdPipe     <= '0;
      hostRdData <= '0;
    end else begin
      codecValid <= accept;
      if (accept) begin
        codecWrite <= hostCmdWord[23];
        codecAddr  <= hostCmdWord[22:16];
        codecData  <= hostCmdWord[15:0];
      end
      if (hostEnWe && strobe.hostOpen) chanEnable <= {hostEnWord[9], hostEnWord[8]};
      rdPipe <= {rdPipe[RD_LAT-2:0], accept && !hostCmdWord[23]};
      if (rdPipe[RD_LAT-2]) hostRdData <= codecRdData;
    end
  end

  assign hostRdValid = rdPipe[RD_LAT-1];
endmodule

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
  import codec_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int GAP_MS     = 5,
  parameter int RD_LAT     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostCmdValid,
  input  logic [23:0]        hostCmdWord,
  output logic               hostBusy,
  output logic               hostRdValid,
  output logic [15:0]        hostRdData,
  input  logic               hostEnWe,
  input  logic [9:8]         hostEnWord,
  output logic [1:0]         chanEnable,
  output logic               codecValid,
  output logic               codecWrite,
  output logic [6:0]         codecAddr,
  output logic [15:0]        codecData,
  input  logic [15:0]        codecRdData,
  output logic               ctrlWe,
  output logic [15:0]        ctrlData,
  output logic               chanWe,
  output logic [CHAN_IW-1:0] chanIdx,
  output logic [CHAN_DW-1:0] chanData,
  output logic               initDone
);
  seq_strobe_t strobe;

  codec_seq_ctrl #(.CLK_PER_MS(CLK_PER_MS), .GAP_MS(GAP_MS)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  codec_seq_dp #(.RD_LAT(RD_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostCmdValid(hostCmdValid), .hostCmdWord(hostCmdWord),
    .hostRdValid(hostRdValid), .hostRdData(hostRdData),
    .hostEnWe(hostEnWe), .hostEnWord(hostEnWord), .chanEnable(chanEnable),
    .codecValid(codecValid), .codecWrite(codecWrite), .codecAddr(codecAddr),
    .codecData(codecData), .codecRdData(codecRdData),
    .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .chanWe(chanWe), .chanIdx(chanIdx), .chanData(chanData)
  );

  assign hostBusy = !strobe.hostOpen;
  assign initDone = strobe.hostOpen;
endmodule

// File: rtl/codec_cmd_seq_chk.sv
module codec_cmd_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostBusy,
  input logic [1:0]  chanEnable,
  input logic        codecValid,
  input logic        ctrlWe,
  input logic        chanWe,
  input logic [31:0] chanData,
  input logic        initDone
);
  AST_CTRL_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> !ctrlWe) else $error("ctrl strobes back to back"); // R3
  AST_CHAN_DESCEND: assert property (@(posedge clk) disable iff (!rstN)
    (chanWe && $past(chanWe)) |-> (chanData == $past(chanData) - 32'd1))
    else $error("channel pattern not descending"); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone) else $error("done fell"); // R5
  AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hostBusy |=> !codecValid) else $error("command issued while busy"); // R7
  AST_FILL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWe && chanWe)) else $error("ctrl and chan strobes overlap"); // R4
  AST_EN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hostBusy |=> $stable(chanEnable)) else $error("enable changed while busy"); // R9
endmodule

bind codec_cmd_seq codec_cmd_seq_chk u_chk (.*);

// File: tb/codec_cmd_seq_tb.sv
`timescale 1ns/1ps
module codec_cmd_seq_tb;
  localparam int CLK_PER_MS = 4;
  localparam int GAP_MS     = 5;
  localparam int RD_LAT     = 3;
  localparam int G          = CLK_PER_MS * GAP_MS;
  localparam int CHAN_K0    = 5 * G + 2;
  localparam int DONE_K     = 5 * G + 34;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCmdValid = 1'b0;
  logic [23:0] hostCmdWord = '0;
  logic        hostBusy, hostRdValid;
  logic [15:0] hostRdData;
  logic        hostEnWe = 1'b0;
  logic [9:8]  hostEnWord = '0;
  logic [1:0]  chanEnable;
  logic        codecValid, codecWrite;
  logic [6:0]  codecAddr;
  logic [15:0] codecData;
  logic [15:0] codecRdData = '0;
  logic        ctrlWe;
  logic [15:0] ctrlData;
  logic        chanWe;
  logic [4:0]  chanIdx;
  logic [31:0] chanData;
  logic        initDone;

  int checks = 0;
  int errors = 0;
  int ctrlSeen = 0;
  int chanSeen = 0;
  int cmdSent = 0;
  int cmdSeen = 0;

  always #10 clk = ~clk;

  codec_cmd_seq #(.CLK_PER_MS(CLK_PER_MS), .GAP_MS(GAP_MS), .RD_LAT(RD_LAT)) u_dut (.*);

  logic [15:0] seqVals [6] = '{16'h00a8, 16'h80a8, 16'h80e8, 16'h80a8, 16'h00a8, 16'h00e8};

  // reference model state
  int          k = 0;
  logic        mCv = 1'b0, mCw = 1'b0, mRv = 1'b0;
  logic [6:0]  mCa = '0;
  logic [15:0] mCd = '0, mRd = '0;
  logic [1:0]  mEn = '0;
  int          due[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      k = 0; mCv = 0; mRv = 0; mEn = '0; due.delete();
    end else begin
      bit busyNow;
      int newK;
      busyNow = (k < DONE_K);
      newK = k + 1;
      mCv = 0;
      if (hostCmdValid && !busyNow) begin
        mCv = 1; mCw = hostCmdWord[23]; mCa = hostCmdWord[22:16]; mCd = hostCmdWord[15:0];
        if (!hostCmdWord[23]) due.push_back(newK + RD_LAT - 1);
      end
      if (hostEnWe && !busyNow) mEn = {hostEnWord[9], hostEnWord[8]};
      mRv = 0;
      if (due.size() > 0 && due[0] == newK) begin
        void'(due.pop_front());
        mRv = 1; mRd = codecRdData;
      end
      k = newK;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit eCtrl, eChan, eDone;
    eCtrl = (k >= 1) && (k <= 1 + 5 * G) && ((k - 1) % G == 0);
    eChan = (k >= CHAN_K0) && (k < CHAN_K0 + 32);
    eDone = (k >= DONE_K);
    chk(ctrlWe == eCtrl, "R3 ctrlWe timing", ctrlWe, eCtrl);
    if (eCtrl) chk(ctrlData == seqVals[(k - 1) / G], "R2 ctrlData", ctrlData, seqVals[(k - 1) / G]);
    chk(chanWe == eChan, "R4 chanWe timing", chanWe, eChan);
    if (eChan) begin
      chk(chanIdx == 5'(k - CHAN_K0), "R4 chanIdx", chanIdx, k - CHAN_K0);
      chk(chanData == 32'(0) - 32'(k - CHAN_K0), "R4 chanData", chanData, 32'(0) - 32'(k - CHAN_K0));
    end
    chk(initDone == eDone, "R5 initDone", initDone, eDone);
    chk(hostBusy == !eDone, "R5 hostBusy", hostBusy, !eDone);
    chk(codecValid == mCv, "R7 codecValid", codecValid, mCv);
    if (mCv) begin
      chk(codecWrite == mCw, "R6 codecWrite", codecWrite, mCw);
      chk(codecAddr == mCa, "R6 codecAddr", codecAddr, mCa);
      if (mCw) chk(codecData == mCd, "R6 codecData", codecData, mCd);
    end
    chk(hostRdValid == mRv, "R8 hostRdValid", hostRdValid, mRv);
    if (mRv) chk(hostRdData == mRd, "R8 hostRdData", hostRdData, mRd);
    chk(chanEnable == mEn, "R9 chanEnable", chanEnable, mEn);
    if (rstN && ctrlWe) ctrlSeen++;
    if (rstN && chanWe) chanSeen++;
    if (rstN && codecValid) cmdSeen++;
  end

  task automatic sendCmd(input logic [23:0] w);
    @(negedge clk);
    hostCmdValid = 1'b1; hostCmdWord = w;
    while (hostBusy) @(negedge clk);
    @(negedge clk);
    hostCmdValid = 1'b0;
    cmdSent++;
  endtask

  task automatic enWrite(input logic [1:0] v);
    @(negedge clk);
    hostEnWe = 1'b1; hostEnWord = v;
    @(negedge clk);
    hostEnWe = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ctrlWe && !chanWe && !codecValid && !hostRdValid, "R1 strobes low in reset", {ctrlWe, chanWe, codecValid, hostRdValid}, 0);
    chk(hostBusy && !initDone, "R1 busy in reset", {hostBusy, initDone}, 2'b10);
    chk(chanEnable == 2'b00, "R1 enable cleared", chanEnable, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    enWrite(2'b11);                          // R9: ignored while busy
    chk(chanEnable == 2'b00, "R9 enable ignored while busy", chanEnable, 0);
    sendCmd({1'b1, 7'h12, 16'hbeef});       // R7: held through the stall
    chk(ctrlSeen == 6, "R2 six control writes", ctrlSeen, 6);
    chk(chanSeen == 32, "R4 thirty-two channel writes", chanSeen, 32);
    enWrite(2'b01);
    chk(chanEnable == 2'b01, "R9 channel 0 enable", chanEnable, 2'b01);
    enWrite(2'b10);
    chk(chanEnable == 2'b10, "R9 channel 1 enable", chanEnable, 2'b10);
    codecRdData = 16'h1234;
    sendCmd({1'b0, 7'h26, 16'h0000});       // R8 read
    repeat (4) @(negedge clk);
    // R10: back-to-back mixed commands, read data changing every cycle
    for (int i = 0; i < 6; i++) begin
      hostCmdValid = 1'b1;
      hostCmdWord = {i[0], 7'(8'h40 + i), 16'(16'ha000 + i)};
      codecRdData = 16'(16'h5500 + i);
      cmdSent++;
      @(negedge clk);
    end
    hostCmdValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      codecRdData = 16'(16'h7700 + i);
      @(negedge clk);
    end
    chk(cmdSeen == cmdSent, "R7 no command dropped", cmdSeen, cmdSent);
    // reset in mid bring-up restarts the sequence
    rstN = 1'b0;
    ctrlSeen = 0; chanSeen = 0;
    repeat (2) @(negedge clk);
    chk(!initDone && chanEnable == 2'b00, "R1 reset clears done and enable", {initDone, chanEnable}, 0);
    rstN = 1'b1;
    repeat (3 * G) @(negedge clk);
    rstN = 1'b0;
    ctrlSeen = 0; chanSeen = 0;
    @(negedge clk);
    rstN = 1'b1;
    while (!initDone) @(negedge clk);
    chk(ctrlSeen == 6, "R2 six writes after re-reset", ctrlSeen, 6);
    chk(chanSeen == 32, "R4 full fill after re-reset", chanSeen, 32);
    repeat (20) @(negedge clk);
    chk(initDone, "R5 done stays high", initDone, 1);
    summary();
  end
endmodule